// File: doc/BRIEF.md
# Master Frame Sync and Delayed Slave Sync Generator

This block sits in the master converter of a daisy chain in which several converters share one serial data bus. It is clocked by the shift clock and keeps a free-running position inside a 256-clock sampling frame. At fixed points in the frame it drives an active-low frame sync, one strobe per device. It also drives an active-low delayed sync that opens the first slave's time slot, and a slot-enable that lets the master drive its data output only during its own slot. Outside that slot the data output stays at high impedance.

The slot spacing comes from a six-bit delay field and the chain length from a two-bit slave-count field, both read from a control register. Both fields are captured only at frame boundaries, so a field written mid-frame takes effect from the next frame. Every frame has a primary phase that starts at count 0. A secondary request, sampled when the master's primary strobe ends, adds a second phase in the same frame that starts at count 128 and repeats the same slot pattern.

Top module: `frame_sync_master`

## Requirements
- R1: While reset is high, fs_n and fsd_n are 1 and own_slot is 0. On the first clock after reset is released the frame count starts at 0, so fs_n is low in the cycle that follows that edge.
- R2: The frame repeats every 256 shift clocks. With no slaves, fs_n is low for exactly 16 clocks at counts 0 to 15 and, with no secondary phase, high for the rest of the frame.
- R3: own_slot is 1 exactly during slot 0 of each active phase (16 clocks from the phase start) and 0 at all other times.
- R4: With at least one slave, fsd_n is low for 16 clocks starting S clocks after the phase start, where S is the effective spacing. S is the delay field adjusted by R6 and R7.
- R5: With slave count N (field value 0 to 3), fs_n is low in every slot k from 0 to N. Slot k covers offsets k*S to k*S+15 from the phase start.
- R6: A delay field below 16, including 0, gives an effective spacing of 16.
- R7: The effective spacing is limited to floor(128/(N+1)): 128, 64, 42 or 32 clocks for N = 0 to 3.
- R8: The delay and slave-count fields are captured only on the first clock after reset and on the clock that ends count 255. A change at any other time has no effect on the outputs until the next frame.
- R9: sec_req is sampled on the clock that ends count 15. If it is 1, the slot pattern of R3 to R5 repeats with count 128 as the phase start. If it is 0, the outputs stay idle from count 128 to 255.
- R10: With a slave count of 0, fsd_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_cfg | input | 6 | Slot spacing in shift clocks |
| nslv_cfg | input | 2 | Number of slaves on the chain |
| sec_req | input | 1 | Secondary phase request |
| fs_n | output | 1 | Active-low frame sync, one strobe per device slot |
| fsd_n | output | 1 | Active-low delayed sync for the first slave |
| own_slot | output | 1 | High while the master may drive its data output |

## Verification
The bench probes the clamps at both ends. A delay of 5 must space the slots as if it were 16; a design that skips this clamp would overlap the slots and merge the strobes. A delay of 63 with three slaves must shrink to 32; without that limit the last primary slot would run into the secondary phase. The bench also changes the fields and the secondary request mid-frame, which catches a design that samples them at the wrong count and so shifts or tears a frame. Reset is applied a second time in the middle of a run, which catches a counter that restarts from a stale position.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    parameter int FRAME_LEN  = 256;
    parameter int SYNC_LEN   = 16;
    parameter int MAX_SLAVES = 3;
    parameter int DLY_W      = 6;

    localparam int CNT_W  = $clog2(FRAME_LEN);
    localparam int HALF   = FRAME_LEN / 2;
    localparam int OFF_W  = CNT_W - 1;
    localparam int NDEV   = MAX_SLAVES + 1;
    localparam int NSLV_W = $clog2(NDEV);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        logic [NSLV_W-1:0] nslv;
        off_t              spacing;
    } cfg_t;

    // Lower bound keeps slots apart; upper bound keeps a full phase in half a frame.
    function automatic off_t eff_spacing(input logic [DLY_W-1:0] d,
                                         input logic [NSLV_W-1:0] n);
        int v;
        int lim;
        lim = HALF;
        for (int k = 0; k < NDEV; k++) begin
            if (int'(n) == k) lim = HALF / (k + 1);
        end
        v = (int'(d) < SYNC_LEN) ? SYNC_LEN : int'(d);
        if (v > lim) v = lim;
        return off_t'(v);
    endfunction
endpackage

// File: rtl/fsync_timebase.sv
module fsync_timebase
    import fsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic run,
    output cnt_t cnt,
    output logic frame_end,
    output logic prim_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            run <= 1'b1;
            if (!run || cnt == cnt_t'(FRAME_LEN - 1))
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign frame_end = run && (cnt == cnt_t'(FRAME_LEN - 1));
    assign prim_done = run && (cnt == cnt_t'(SYNC_LEN - 1));
endmodule

// File: rtl/fsync_cfg.sv
module fsync_cfg
    import fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              frame_end,
    input  logic              prim_done,
    input  logic [DLY_W-1:0]  dly_in,
    input  logic [NSLV_W-1:0] nslv_in,
    input  logic              sec_req,
    output cfg_t              cfg,
    output logic              sec_armed
);
    logic load;
    assign load = !run || frame_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            sec_armed <= 1'b0;
        end else begin
            if (load) begin
                cfg.nslv    <= nslv_in;
                cfg.spacing <= eff_spacing(dly_in, nslv_in);
            end
            if (load)
                sec_armed <= 1'b0;
            else if (prim_done)
                sec_armed <= sec_req;
        end
    end
endmodule

// File: rtl/fsync_slot_decode.sv
module fsync_slot_decode
    import fsync_pkg::*;
(
    input  logic            run,
    input  cnt_t            cnt,
    input  cfg_t            cfg,
    input  logic            sec_armed,
    output logic [NDEV-1:0] hit
);
    logic phase_ok;
    cnt_t off_w;

    assign phase_ok = run && (!cnt[CNT_W-1] || sec_armed);
    assign off_w    = {1'b0, cnt[OFF_W-1:0]};

    for (genvar k = 0; k < NDEV; k++) begin : g_slot
        cnt_t start_pos;
        cnt_t end_pos;
        assign start_pos = cnt_t'(k) * {1'b0, cfg.spacing};
        assign end_pos   = start_pos + cnt_t'(SYNC_LEN);
        assign hit[k]    = phase_ok && (int'(cfg.nslv) >= k)
                           && (off_w >= start_pos) && (off_w < end_pos);
    end
endmodule

// File: rtl/frame_sync_master.sv
module frame_sync_master
    import fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DLY_W-1:0]  dly_cfg,
    input  logic [NSLV_W-1:0] nslv_cfg,
    input  logic              sec_req,
    output logic              fs_n,
    output logic              fsd_n,
    output logic              own_slot
);
    logic            run;
    cnt_t            cnt;
    logic            frame_end;
    logic            prim_done;
    cfg_t            cfg;
    logic            sec_armed;
    logic [NDEV-1:0] hit;

    fsync_timebase u_tb (
        .clk(clk), .rst(rst), .run(run), .cnt(cnt),
        .frame_end(frame_end), .prim_done(prim_done)
    );

    fsync_cfg u_cfg (
        .clk(clk), .rst(rst), .run(run), .frame_end(frame_end),
        .prim_done(prim_done), .dly_in(dly_cfg), .nslv_in(nslv_cfg),
        .sec_req(sec_req), .cfg(cfg), .sec_armed(sec_armed)
    );

    fsync_slot_decode u_dec (
        .run(run), .cnt(cnt), .cfg(cfg), .sec_armed(sec_armed), .hit(hit)
    );

    assign fs_n     = ~(|hit);
    assign own_slot = hit[0];

    if (MAX_SLAVES > 0) begin : g_fsd
        assign fsd_n = ~hit[1];
    end else begin : g_nofsd
        assign fsd_n = 1'b1;
    end
endmodule

// File: rtl/frame_sync_master_chk.sv
module frame_sync_master_chk
    import fsync_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic fs_n,
    input logic fsd_n,
    input logic own_slot
);
    logic [7:0] own_len;

    always_ff @(posedge clk) begin
        if (rst)           own_len <= '0;
        else if (own_slot) own_len <= own_len + 1'b1;
        else               own_len <= '0;
    end

    // R1: reset forces all outputs idle
    a_r1_idle_in_reset: assert property (@(posedge clk)
        rst |=> (fs_n && fsd_n && !own_slot));

    // R1: the master strobe starts right after release
    a_r1_start_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (!fs_n && own_slot));

    // R3: own slot is always inside a frame sync
    a_r3_own_within_fs: assert property (@(posedge clk) disable iff (rst)
        own_slot |-> !fs_n);

    // R3: own slot never exceeds one sync length
    a_r3_own_len: assert property (@(posedge clk) disable iff (rst)
        own_slot |-> (int'(own_len) < SYNC_LEN));

    // R4: delayed sync never overlaps the master slot
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(own_slot && !fsd_n));

    // R4: delayed sync is held low after it falls
    a_r4_fsd_width: assert property (@(posedge clk) disable iff (rst)
        $fell(fsd_n) |=> !fsd_n);

    // R2: frame sync is held low after it falls
    a_r2_fs_width: assert property (@(posedge clk) disable iff (rst)
        $fell(fs_n) |=> !fs_n);
endmodule

bind frame_sync_master frame_sync_master_chk u_chk (
    .clk(clk), .rst(rst), .fs_n(fs_n), .fsd_n(fsd_n), .own_slot(own_slot)
);

// File: tb/frame_sync_master_bench.sv
`timescale 1ns/1ps
module frame_sync_master_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] dly_cfg = '0;
    logic [1:0] nslv_cfg = '0;
    logic       sec_req = 1'b0;
    logic       fs_n, fsd_n, own_slot;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [2:0] v;
        string      tag;
    } item_t;
    item_t q[$];

    // reference state, advanced from the requirements
    bit m_run = 0;
    int m_cnt = 0;
    int m_n   = 0;
    int m_s   = 16;
    bit m_sec = 0;

    always #2.5 clk = ~clk;

    frame_sync_master u_frame_sync_master (
        .clk(clk), .rst(rst), .dly_cfg(dly_cfg), .nslv_cfg(nslv_cfg),
        .sec_req(sec_req), .fs_n(fs_n), .fsd_n(fsd_n), .own_slot(own_slot)
    );

    function automatic int spacing_of(int d, int n);
        int s;
        int lim;
        s   = (d < 16) ? 16 : d;       // R6
        lim = 128 / (n + 1);           // R7
        return (s > lim) ? lim : s;
    endfunction

    function automatic logic [2:0] expect_now();
        logic fs, fsd, own;
        int   off;
        fs = 1; fsd = 1; own = 0;
        if (m_run && (m_cnt < 128 || m_sec)) begin
            off = m_cnt % 128;
            for (int k = 0; k <= m_n; k++) begin
                if (off >= k * m_s && off < k * m_s + 16) begin
                    fs = 0;
                    if (k == 0) own = 1;
                    if (k == 1) fsd = 0;
                end
            end
        end
        return {fs, fsd, own};
    endfunction

    task automatic drive(input int ncyc, input int d, input int n,
                         input bit sreq, input bit r, input string tag);
        item_t it;
        for (int i = 0; i < ncyc; i++) begin
            rst = r; dly_cfg = 6'(d); nslv_cfg = 2'(n); sec_req = sreq;
            if (r) begin
                m_run = 0; m_cnt = 0; m_n = 0; m_s = 16; m_sec = 0;
            end else if (!m_run) begin
                m_run = 1; m_cnt = 0; m_n = n; m_s = spacing_of(d, n); m_sec = 0;
            end else begin
                if (m_cnt == 255) begin
                    m_n = n; m_s = spacing_of(d, n); m_sec = 0;
                end else if (m_cnt == 15) begin
                    m_sec = sreq;
                end
                m_cnt = (m_cnt + 1) % 256;
            end
            it.v = expect_now(); it.tag = tag;
            q.push_back(it);
            @(negedge clk);
            #1;
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if ({fs_n, fsd_n, own_slot} !== it.v) begin
                n_bad++;
                $display("FAIL %s: fs_n/fsd_n/own_slot got %b%b%b expected %b",
                         it.tag, fs_n, fsd_n, own_slot, it.v);
            end
        end
    end

    initial begin
        #1;
        drive(8,   0, 0, 0, 1, "R1 reset idle");
        drive(600, 0, 0, 0, 0, "R1 R2 R3 R10 R6 no slaves");
        drive(600, 20, 1, 0, 0, "R4 R5 one slave");
        drive(600, 5, 3, 0, 0, "R6 R5 small delay");
        drive(600, 63, 3, 0, 0, "R7 three slaves clamp");
        drive(600, 50, 2, 0, 0, "R7 two slaves clamp");
        drive(600, 24, 2, 1, 0, "R9 secondary on");
        drive(300, 24, 2, 0, 0, "R9 secondary off");
        drive(100, 30, 1, 1, 0, "R8 before change");
        drive(500, 16, 3, 0, 0, "R8 after change");
        drive(5,   40, 1, 1, 1, "R1 second reset");
        drive(600, 40, 1, 1, 0, "R1 R9 restart");
        drive(3,   0, 0, 0, 0, "R2 tail");
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule